// File: doc/BRIEF.md
# Three-Wire Serial Register Access Controller

This block is the device end of a three-wire host link made of an enable line, a serial clock and a data line. A fast system clock samples all three inputs. Each transfer opens with an 8-bit command, sent least significant bit first. The command picks a read or a write and either one register or a burst through all eight entries of a small register array. Seven entries are plain 8-bit registers. The eighth holds a single write-protect flag. Data is also sent least significant bit first. The data line is driven only through an output enable.

Every register write that takes effect appears on a one-cycle strobe with its address and the value stored. Timekeeping logic beside the array can follow those strobes. The controller is a five-state machine:

- S_IDLE waits for enable.
- S_CMD shifts in the command.
- S_WRITE takes in data bytes.
- S_READ shifts data out.
- S_SKIP absorbs clocks that must have no effect.

The transitions are:

- Any state goes to S_IDLE when enable is low.
- S_IDLE goes to S_CMD when enable is high.
- S_CMD, on its eighth rising clock, goes to S_WRITE or S_READ for a valid command, or to S_SKIP for a reserved or malformed one.
- S_WRITE goes to S_SKIP after the last byte it accepts: one byte for a single access, eight for a burst.
- S_READ and S_SKIP stay where they are until enable drops.

Top module: `tws_ctrl`

## Requirements
- R1: Enable low aborts any transfer and turns the data output enable off within a few system clocks. The next rise of enable starts a fresh command.
- R2: The command is taken bit 0 first. Bit 0 is the direction (0 write, 1 read) and bits 3:1 are the address. A single-register command needs bit 7 = 1 and bits 6:4 = 000.
- R3: Command 0xBE starts a burst write and 0xBF a burst read. A burst visits addresses 0 to 7 in order, each byte bit 0 first.
- R4: A command with bit 7 = 1, bits 6:4 = 001 and bit 0 = 1 is reserved. It, and any command with bit 7 = 0, writes nothing and never drives the data line.
- R5: Input bits are captured on rising serial-clock edges and output bits change on falling edges. The first read bit appears on the first falling edge after the eighth command bit, and the data line is not driven before it.
- R6: While enable stays high, a single read keeps resending the same register, and a burst read wraps from address 7 back to 0.
- R7: A byte is written only after all eight of its bits have arrived. A byte cut short by enable going low is dropped. Clocks after the one byte of a single write are ignored.
- R8: Address 7 stores only bit 7, the write-protect flag, and reads with bits 6:0 = 0. While the flag is 1, writes to addresses 0 to 6 are blocked and produce no strobe. A single write to address 7 always works.
- R9: A burst write never changes the write-protect flag. Its eighth byte has no effect.
- R10: Each write that takes effect gives exactly one one-cycle strobe carrying the address and the stored value.
- R11: After reset all registers and the write-protect flag are 0 and the data line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Transfer enable from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Data line as seen by the block |
| sdio_o | output | 1 | Data driven toward the host |
| sdio_oe | output | 1 | Output enable for sdio_o |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | 3 | Address of the committed write |
| reg_wdata_o | output | 8 | Value stored by the committed write |

## Verification
Single writes and reads use distinct values at different addresses, so a swapped bit order or a misdecoded address shows as a wrong byte. Reads that run past eight bits tell retransmission apart from burst wraparound. A nine-byte burst read confirms that address 7 follows address 6 and is followed by address 0. Cut-short bytes, surplus clocks, reserved and malformed commands, and writes with the protect flag set each leave the register contents and the strobe count unchanged, which separates correct commit timing and gating from writes that land early or leak through.

// File: rtl/tws_pkg.sv
package tws_pkg;
    localparam int CMD_W    = 8;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = $clog2(NUM_REGS);

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_WRITE,
        S_READ,
        S_SKIP
    } tws_state_e;

    typedef enum logic [1:0] {
        K_SINGLE,
        K_BURST,
        K_TEST,
        K_BAD
    } cmd_kind_e;

    function automatic cmd_kind_e decode_cmd(input logic [CMD_W-1:0] cmd);
        cmd_kind_e k;
        if (!cmd[7])                          k = K_BAD;
        else if (cmd[6:4] == 3'b001 && cmd[0]) k = K_TEST;
        else if (cmd[6:1] == 6'b011111)        k = K_BURST;
        else if (cmd[6:4] == 3'b000)           k = K_SINGLE;
        else                                   k = K_BAD;
        return k;
    endfunction
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
    import tws_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          sdi_s,
    input  logic [W-1:0]  rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_req,
    output logic          wr_burst,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  wr_data,
    output logic          sdo,
    output logic          sdo_oe
);
    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST_BIT  = BW'(W - 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'((1 << AW) - 1);

    tws_state_e     state_q, state_d;
    logic [BW-1:0]  bit_q;
    logic [W-1:0]   sh_q;
    logic [AW-1:0]  addr_q;
    logic           burst_q;
    logic [W-1:0]   cmd_w;
    cmd_kind_e      kind_w;
    logic           byte_done;

    assign cmd_w     = {sdi_s, sh_q[W-1:1]};
    assign kind_w    = decode_cmd(cmd_w);
    assign byte_done = sclk_rise && (bit_q == LAST_BIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (ce_s) state_d = S_CMD;
            S_CMD:   if (byte_done) begin
                         if (kind_w == K_SINGLE || kind_w == K_BURST)
                             state_d = cmd_w[0] ? S_READ : S_WRITE;
                         else
                             state_d = S_SKIP;
                     end
            S_WRITE: if (byte_done && (!burst_q || addr_q == LAST_ADDR))
                         state_d = S_SKIP;
            S_READ:  state_d = S_READ;
            S_SKIP:  state_d = S_SKIP;
        endcase
        if (!ce_s) state_d = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q    <= '0;
            sh_q     <= '0;
            addr_q   <= '0;
            burst_q  <= 1'b0;
            wr_req   <= 1'b0;
            wr_burst <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            sdo      <= 1'b0;
            sdo_oe   <= 1'b0;
        end else begin
            wr_req <= 1'b0;
            if (!ce_s) begin
                bit_q  <= '0;
                sdo_oe <= 1'b0;
            end else begin
                unique case (state_q)
                    S_IDLE: bit_q <= '0;
                    S_CMD: if (sclk_rise) begin
                        sh_q  <= cmd_w;
                        bit_q <= bit_q + 1'b1;
                        if (bit_q == LAST_BIT) begin
                            burst_q <= (kind_w == K_BURST);
                            addr_q  <= (kind_w == K_BURST) ? '0 : cmd_w[AW:1];
                        end
                    end
                    S_WRITE: if (sclk_rise) begin
                        sh_q  <= cmd_w;
                        bit_q <= bit_q + 1'b1;
                        if (bit_q == LAST_BIT) begin
                            wr_req   <= 1'b1;
                            wr_burst <= burst_q;
                            wr_addr  <= addr_q;
                            wr_data  <= cmd_w;
                            addr_q   <= addr_q + 1'b1;
                        end
                    end
                    S_READ: if (sclk_fall) begin
                        sdo_oe <= 1'b1;
                        bit_q  <= bit_q + 1'b1;
                        if (bit_q == '0) begin
                            sdo  <= rd_data[0];
                            sh_q <= {1'b0, rd_data[W-1:1]};
                        end else begin
                            sdo  <= sh_q[0];
                            sh_q <= {1'b0, sh_q[W-1:1]};
                        end
                        if (bit_q == LAST_BIT && burst_q) addr_q <= addr_q + 1'b1;
                    end
                    S_SKIP: ;
                endcase
            end
        end
    end

    assign rd_addr = addr_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> !sdo_oe); // R1
    AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> state_q == S_READ); // R5
    AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_SKIP |=> !wr_req); // R4
    AST_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> bit_q == '0); // R7
endmodule

// File: rtl/tws_regs.sv
module tws_regs
    import tws_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int NR = NUM_REGS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_req,
    input  logic                  wr_burst,
    input  logic [$clog2(NR)-1:0] wr_addr,
    input  logic [W-1:0]          wr_data,
    input  logic [$clog2(NR)-1:0] rd_addr,
    output logic [W-1:0]          rd_data,
    output logic                  we_o,
    output logic [$clog2(NR)-1:0] we_addr_o,
    output logic [W-1:0]          we_data_o
);
    localparam int AW = $clog2(NR);
    localparam logic [AW-1:0] WP_ADDR = AW'(NR - 1);

    logic [W-1:0] regs_q [NR-1];
    logic         wp_q;
    logic         is_wp, commit_data, commit_wp;

    assign is_wp       = (wr_addr == WP_ADDR);
    assign commit_data = wr_req && !is_wp && !wp_q;
    assign commit_wp   = wr_req && is_wp && !wr_burst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR - 1; i++) regs_q[i] <= '0;
            wp_q      <= 1'b0;
            we_o      <= 1'b0;
            we_addr_o <= '0;
            we_data_o <= '0;
        end else begin
            for (int i = 0; i < NR - 1; i++)
                if (commit_data && wr_addr == AW'(i)) regs_q[i] <= wr_data;
            if (commit_wp) wp_q <= wr_data[W-1];
            we_o <= commit_data || commit_wp;
            if (commit_data || commit_wp) begin
                we_addr_o <= wr_addr;
                we_data_o <= is_wp ? {wr_data[W-1], {(W-1){1'b0}}} : wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == WP_ADDR) rd_data = {wp_q, {(W-1){1'b0}}};
        else
            for (int i = 0; i < NR - 1; i++)
                if (rd_addr == AW'(i)) rd_data = regs_q[i];
    end

    AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wp_q && !is_wp) |=> !we_o); // R8
    AST_BURST_KEEPS_WP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_burst) |=> $stable(wp_q)); // R9
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> !we_o); // R10
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
    import tws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              sclk_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [REG_W-1:0]  reg_wdata_o
);
    localparam int SYNC_STAGES = 2;

    logic [2:0]        sync_w;
    logic              ce_s, sclk_s, sdi_s, sclk_prev_q;
    logic              sclk_rise, sclk_fall;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [REG_W-1:0]  rd_data, wr_data;
    logic              wr_req, wr_burst;

    tws_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ce_i, sclk_i, sdio_i}),
        .q_o   (sync_w)
    );

    assign {ce_s, sclk_s, sdi_s} = sync_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    assign sclk_rise = sclk_s && !sclk_prev_q;
    assign sclk_fall = !sclk_s && sclk_prev_q;

    tws_fsm #(.W(REG_W), .AW(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_s      (ce_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_req    (wr_req),
        .wr_burst  (wr_burst),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (sdio_o),
        .sdo_oe    (sdio_oe)
    );

    tws_regs #(.W(REG_W), .NR(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .wr_burst  (wr_burst),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .we_o      (reg_we_o),
        .we_addr_o (reg_addr_o),
        .we_data_o (reg_wdata_o)
    );
endmodule

// File: tb/tws_ctrl_tb.sv
module tws_ctrl_tb;
    localparam int H = 8;

    logic       clk = 0, rst_n = 0;
    logic       ce = 0, sclk = 0, sdi = 0;
    logic       sdo, oe, we;
    logic [2:0] waddr;
    logic [7:0] wdata;

    int n_chk = 0, n_fail = 0, we_cnt = 0;
    logic [2:0] last_a;
    logic [7:0] last_d;
    logic [7:0] expv [8];

    always #2 clk = ~clk;

    tws_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdio_i(sdi),
        .sdio_o(sdo), .sdio_oe(oe), .reg_we_o(we), .reg_addr_o(waddr),
        .reg_wdata_o(wdata)
    );

    always @(negedge clk) if (rst_n && we) begin
        we_cnt++;
        last_a = waddr;
        last_d = wdata;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_x();
        @(negedge clk); sclk = 0; ce = 1; wait_n(H);
    endtask

    task automatic end_x();
        @(negedge clk); sclk = 0; wait_n(H); ce = 0; wait_n(2*H);
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk); sclk = 0; sdi = b; wait_n(H);
        sclk = 1; wait_n(H);
    endtask

    task automatic byte_out(input logic [7:0] b);
        for (int i = 0; i < 8; i++) bit_out(b[i]);
    endtask

    task automatic byte_in(output logic [7:0] b, output logic all_on, output logic any_on);
        all_on = 1; any_on = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sclk = 0; wait_n(H);
            b[i] = sdo;
            if (oe) any_on = 1; else all_on = 0;
            sclk = 1; wait_n(H);
        end
    endtask

    task automatic wr1(input logic [2:0] a, input logic [7:0] d);
        begin_x(); byte_out({1'b1, 3'b000, a, 1'b0}); byte_out(d); end_x();
    endtask

    task automatic rd1(input logic [2:0] a, output logic [7:0] d);
        logic all_on, any_on;
        begin_x(); byte_out({1'b1, 3'b000, a, 1'b1}); byte_in(d, all_on, any_on); end_x();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check(oe == 0, "R11 oe after reset", oe, 0);
        rd1(3'd0, d); check(d == 0, "R11 reg0 reset", d, 0);
        rd1(3'd7, d); check(d == 0, "R11 reg7 reset", d, 0);
        check(we_cnt == 0, "R11 no strobe", we_cnt, 0);
    endtask

    task automatic t_single();
        logic [7:0] d;
        int c0 = we_cnt;
        wr1(3'd2, 8'h45); expv[2] = 8'h45;
        check(we_cnt == c0 + 1, "R10 strobe count", we_cnt, c0 + 1);
        check(last_a == 2 && last_d == 8'h45, "R10 strobe addr/data", {last_a, last_d}, {3'd2, 8'h45});
        rd1(3'd2, d); check(d == 8'h45, "R2 R5 read reg2", d, 8'h45);
        wr1(3'd5, 8'hA3); expv[5] = 8'hA3;
        rd1(3'd5, d); check(d == 8'hA3, "R2 read reg5", d, 8'hA3);
    endtask

    task automatic t_retransmit();
        logic [7:0] d; logic a1, a2;
        begin_x(); byte_out(8'b1000_0101);
        for (int k = 0; k < 3; k++) begin
            byte_in(d, a1, a2);
            check(d == 8'h45, "R6 retransmit", d, 8'h45);
        end
        end_x();
    endtask

    task automatic t_burst();
        logic [7:0] d; logic a1, a2;
        int c0 = we_cnt;
        begin_x(); byte_out(8'hBE);
        for (int k = 0; k < 7; k++) begin
            byte_out(8'(8'h11 * (k + 1))); expv[k] = 8'(8'h11 * (k + 1));
        end
        byte_out(8'h80);
        end_x();
        check(we_cnt == c0 + 7, "R3 burst strobes", we_cnt, c0 + 7);
        rd1(3'd7, d); check(d == 0, "R9 burst leaves wp", d, 0);
        begin_x(); byte_out(8'hBF);
        for (int k = 0; k < 9; k++) begin
            byte_in(d, a1, a2);
            check(d == expv[k % 8], "R3 R6 burst read", d, expv[k % 8]);
        end
        end_x();
    endtask

    task automatic t_wp();
        logic [7:0] d;
        int c0;
        wr1(3'd7, 8'hFF);
        check(last_a == 7 && last_d == 8'h80, "R10 R8 wp strobe", {last_a, last_d}, {3'd7, 8'h80});
        rd1(3'd7, d); check(d == 8'h80, "R8 reg7 readback", d, 8'h80);
        c0 = we_cnt;
        wr1(3'd0, 8'h99);
        rd1(3'd0, d); check(d == expv[0], "R8 write blocked", d, expv[0]);
        check(we_cnt == c0, "R8 no strobe when protected", we_cnt, c0);
        begin_x(); byte_out(8'hBE);
        for (int k = 0; k < 8; k++) byte_out(8'h00);
        end_x();
        rd1(3'd4, d); check(d == expv[4], "R8 burst blocked", d, expv[4]);
        rd1(3'd7, d); check(d == 8'h80, "R9 burst cannot clear wp", d, 8'h80);
        wr1(3'd7, 8'h00);
        rd1(3'd7, d); check(d == 0, "R8 wp cleared", d, 0);
    endtask

    task automatic t_partial();
        logic [7:0] d;
        int c0 = we_cnt;
        begin_x(); byte_out(8'b1000_0010);
        for (int i = 0; i < 5; i++) bit_out(1'b1);
        end_x();
        rd1(3'd1, d); check(d == expv[1], "R7 partial dropped", d, expv[1]);
        check(we_cnt == c0, "R7 no strobe partial", we_cnt, c0);
        begin_x(); byte_out(8'b1000_0110); byte_out(8'h5A);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        end_x(); expv[3] = 8'h5A;
        rd1(3'd3, d); check(d == 8'h5A, "R7 extra clocks ignored", d, 8'h5A);
        check(we_cnt == c0 + 1, "R7 one strobe", we_cnt, c0 + 1);
    endtask

    task automatic t_reserved();
        logic [7:0] d; logic a1, a2;
        int c0 = we_cnt;
        begin_x(); byte_out(8'h93); byte_in(d, a1, a2); end_x();
        check(a2 == 0, "R4 test cmd no drive", a2, 0);
        begin_x(); byte_out(8'h91); byte_out(8'hFF); end_x();
        begin_x(); byte_out(8'h0A); byte_out(8'hFF); end_x();
        check(we_cnt == c0, "R4 no write", we_cnt, c0);
        rd1(3'd5, d); check(d == expv[5], "R4 reg5 intact", d, expv[5]);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        begin_x(); byte_out(8'b1000_0101);
        check(oe == 0, "R5 not driven before first fall", oe, 0);
        @(negedge clk); sclk = 0; wait_n(H);
        check(oe == 1 && sdo == expv[2][0], "R5 first bit", {oe, sdo}, {1'b1, expv[2][0]});
        ce = 0; wait_n(6);
        check(oe == 0, "R1 abort releases line", oe, 0);
        wait_n(2*H);
        rd1(3'd2, d); check(d == expv[2], "R1 fresh transfer", d, expv[2]);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) expv[i] = 0;
        wait_n(5); rst_n = 1; wait_n(5);
        t_reset();
        t_single();
        t_retransmit();
        t_burst();
        t_wp();
        t_partial();
        t_reserved();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule